// File: doc/BRIEF.md
# ADC Sample FIFO With Sticky Error Flags

This block buffers conversion results between an analog-to-digital converter and a register-mapped reader. It stores up to four 12-bit samples in arrival order. Samples enter either from the converter's result strobe or from a bus write of a dummy value, which lets software exercise the path with no converter running. The reader pops one sample per read request, and the popped value stays on the output until the next accepted read.

Five status flags are driven continuously: empty, almost-full (exactly three held), full, and two sticky error flags. A push against a full buffer raises the overflow flag and freezes the write side. A pop from an empty buffer raises the underflow flag and freezes the read side, so reads keep returning the last sample popped. Only a flush command clears the error flags. It also empties the buffer and zeroes the held output.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset, empty is 1, almostFull, full, overflow and underflow are 0, and rdData is 0x000.
- R2: Accepted samples are returned in arrival order with all 12 bits intact. rdData changes in the clock cycle after an accepted read and holds its value until the next accepted read.
- R3: empty is 1 exactly when zero samples are held. almostFull is 1 exactly when three samples are held. full is 1 exactly when four samples are held.
- R4: A push while four samples are held sets overflow and the sample is not stored.
- R5: While overflow is 1, no push is stored, even after reads have freed space, until a flush.
- R6: A read while empty leaves rdData unchanged and sets underflow.
- R7: While underflow is 1, reads leave rdData unchanged and remove nothing, even if samples were pushed later, until a flush.
- R8: A bus dummy write (busWrValid) is stored exactly like a converter sample. When adcValid and busWrValid are both 1 in the same cycle, only adcData is stored.
- R9: flush takes priority over every other input in its cycle. It empties the buffer, clears overflow and underflow, and sets rdData to 0x000.
- R10: A simultaneous accepted read and accepted push leaves the held count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| adcValid | input | 1 | Converter result strobe |
| adcData | input | 12 | Converter result |
| busWrValid | input | 1 | Bus write of a dummy sample |
| busWrData | input | 12 | Dummy sample value |
| rdReq | input | 1 | Pop one sample |
| flush | input | 1 | Empty the buffer and clear error flags |
| rdData | output | 12 | Last sample popped |
| empty | output | 1 | No samples held |
| almostFull | output | 1 | Exactly three samples held |
| full | output | 1 | Four samples held |
| overflow | output | 1 | Sticky: push attempted while full |
| underflow | output | 1 | Sticky: read attempted while empty |

## Verification
The directed patterns are as follows:
- A fill to capacity followed by one extra push separates a correct full check from an off-by-one that stores a fifth sample.
- Reads after an overflow, each followed by a push, show whether the write freeze holds once space has been freed.
- Draining past empty and then pushing more samples shows whether the read freeze holds even when data is present.
- Same-cycle converter and bus pushes show the priority between the two sources.
- Same-cycle reads and pushes at mid occupancy show whether the count is kept.

A long random phase with occasional flushes then mixes all of these cases. It is compared cycle by cycle against a queue-based model.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  // strobes from control to datapath, all qualified (already accepted)
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic clear;
  } fifo_strobe_t;
endpackage

// File: rtl/adc_fifo_ctrl.sv
module adc_fifo_ctrl
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pushReq,
  input  logic         popReq,
  input  logic         flush,
  output fifo_strobe_t strobe,
  output logic         empty,
  output logic         almostFull,
  output logic         full,
  output logic         overflow,
  output logic         underflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_AFULL = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] count;
  logic wrOk, rdOk;

  assign empty      = (count == '0);
  assign full       = (count == CNT_FULL);
  assign almostFull = (count == CNT_AFULL);

  // acceptance uses the state at the start of the cycle
  assign wrOk = pushReq && !flush && !overflow && !full;
  assign rdOk = popReq && !flush && !underflow && !empty;

  assign strobe.wrEn  = wrOk;
  assign strobe.rdEn  = rdOk;
  assign strobe.clear = flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (flush) begin
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      case ({wrOk, rdOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pushReq && full) overflow <= 1'b1;
      if (popReq && empty) underflow <= 1'b1;
    end
  end

  assert_full_push_sets_ovf_R4: assert property (@(posedge clk) disable iff (!rstN)
    full && pushReq && !flush |=> overflow);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !flush |=> overflow);
  assert_ovf_no_growth_R5: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !flush && !popReq |=> $stable(count));
  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    underflow && !flush |=> underflow);
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty && !overflow && !underflow);
  assert_rdwr_keeps_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn && strobe.rdEn |=> $stable(count));
  assert_flags_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({empty, almostFull, full}));
endmodule

// File: rtl/adc_fifo_dpath.sv
module adc_fifo_dpath
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifo_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else if (strobe.clear) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= nextPtr(wrPtr);
      if (strobe.rdEn) begin
        rdPtr  <= nextPtr(rdPtr);
        rdData <= mem[rdPtr];
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.wrEn && !strobe.clear && wrPtr == PTR_W'(i)) mem[i] <= wrData;
    end
  end

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn && !strobe.clear |=> $stable(rdData));
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> rdData == '0 && wrPtr == rdPtr);
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcValid,
  input  logic [DATA_W-1:0] adcData,
  input  logic              busWrValid,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              rdReq,
  input  logic              flush,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              almostFull,
  output logic              full,
  output logic              overflow,
  output logic              underflow
);
  fifo_strobe_t      strobe;
  logic              pushReq;
  logic [DATA_W-1:0] pushData;

  // converter result wins over a same-cycle dummy write
  assign pushReq  = adcValid || busWrValid;
  assign pushData = adcValid ? adcData : busWrData;

  adc_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(rdReq), .flush(flush),
    .strobe(strobe), .empty(empty), .almostFull(almostFull), .full(full),
    .overflow(overflow), .underflow(underflow)
  );

  adc_fifo_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(pushData), .rdData(rdData)
  );

  assert_unf_rd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    underflow && !flush |=> $stable(rdData));
endmodule

// File: tb/adc_sample_fifo_tb.sv
module adc_sample_fifo_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic adcValid = 1'b0, busWrValid = 1'b0, rdReq = 1'b0, flush = 1'b0;
  logic [11:0] adcData = '0, busWrData = '0;
  logic [11:0] rdData;
  logic empty, almostFull, full, overflow, underflow;

  int nCmp = 0, nBad = 0;
  int cycles = 0;

  // reference model
  int q[$];
  int mLast = 0;
  bit mOvf = 0, mUnf = 0;

  always #10 clk = ~clk;

  adc_sample_fifo u_dut (
    .clk(clk), .rstN(rstN), .adcValid(adcValid), .adcData(adcData),
    .busWrValid(busWrValid), .busWrData(busWrData), .rdReq(rdReq), .flush(flush),
    .rdData(rdData), .empty(empty), .almostFull(almostFull), .full(full),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "rdData", int'(rdData), mLast);
    chk(tag, "empty", int'(empty), int'(q.size() == 0));
    chk(tag, "almostFull", int'(almostFull), int'(q.size() == 3));
    chk(tag, "full", int'(full), int'(q.size() == 4));
    chk(tag, "overflow", int'(overflow), int'(mOvf));
    chk(tag, "underflow", int'(underflow), int'(mUnf));
  endtask

  task automatic modelEdge();
    int pre;
    pre = q.size();
    if (flush) begin
      q.delete(); mLast = 0; mOvf = 0; mUnf = 0;
    end else begin
      if (rdReq) begin
        if (mUnf || pre == 0) mUnf = 1;
        else mLast = q.pop_front();
      end
      if (adcValid || busWrValid) begin
        if (mOvf) ;
        else if (pre == 4) mOvf = 1;
        else q.push_back(adcValid ? int'(adcData) : int'(busWrData));
      end
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input string tag, input bit a, input int ad, input bit b,
                      input int bd, input bit r, input bit f);
    adcValid = a; adcData = 12'(ad); busWrValid = b; busWrData = 12'(bd);
    rdReq = r; flush = f;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    adcValid = 0; busWrValid = 0; rdReq = 0; flush = 0;
    compareAll(tag);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    nBad++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");
    // R2/R3: fill with converter samples, watch flags
    step("R3", 1, 12'hA01, 0, 0, 0, 0);
    step("R3", 1, 12'hFFF, 0, 0, 0, 0);
    step("R3", 1, 12'h5A5, 0, 0, 0, 0);
    step("R3", 1, 12'h800, 0, 0, 0, 0);
    // R4: push while full
    step("R4", 1, 12'h123, 0, 0, 0, 0);
    // R5: free space then try to push
    step("R5", 0, 0, 0, 0, 1, 0);
    step("R5", 1, 12'h321, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 12'h777, 1, 0);
    step("R2", 0, 0, 0, 0, 1, 0);
    step("R2", 0, 0, 0, 0, 1, 0);
    // R6: read while empty
    step("R6", 0, 0, 0, 0, 1, 0);
    // R9: flush clears overflow and underflow and zeroes output
    step("R9", 1, 12'h111, 0, 0, 1, 1);
    // R8: dummy write, then collision
    step("R8", 0, 0, 1, 12'hBEE, 0, 0);
    step("R8", 1, 12'hCAF, 1, 12'hDED, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 0, 1, 0);
    // R10: simultaneous read/write at mid occupancy
    step("R10", 1, 12'h0F0, 0, 0, 0, 0);
    step("R10", 1, 12'h0F1, 0, 0, 0, 0);
    step("R10", 1, 12'h0F2, 0, 0, 1, 0);
    step("R10", 0, 0, 1, 12'h0F3, 1, 0);
    step("R10", 0, 0, 0, 0, 1, 0);
    step("R10", 0, 0, 0, 0, 1, 0);
    // R7: underflow, then pushes are stored but reads stay frozen
    step("R7", 0, 0, 0, 0, 1, 0);
    step("R7", 1, 12'h9AB, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 0);
    step("R7", 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 1);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      step("R2", 1'($urandom), int'($urandom), 1'($urandom), int'($urandom),
           1'($urandom), ($urandom % 40) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule